// File: doc/BRIEF.md
# Aligned Descriptor Writeback Engine

This engine hands finished descriptors back to a host descriptor ring. It keeps a count of the entries waiting in the cache's used queue. On a writeback request it works out how many of them to write in one DMA burst, waits a programmable delay, and issues a single write request. When the write completes it retires those entries and moves the hardware head pointer forward, wrapping at the ring length. It then publishes the new head.

A request either asks for cache-line alignment or accepts any count. An aligned request rounds the count down to a whole number of cache lines, so a partial line is never written. The count is always clipped at the end of the ring. Only one write is outstanding at a time. A request that arrives mid-write and is less strict than the one in progress is remembered, and the engine starts it by itself once the current write retires. The same happens when the ring end clipped the count.

Two interrupt-delay timers are built in: a per-packet timer that restarts on every event and an absolute timer that does not. When either expires, it forces an unaligned writeback and raises one interrupt cause. The parameter `IS_TX` picks whether that cause is the receive-timer cause or the descriptor-written cause.

Top module: `desc_wb_engine`

## Requirements
- R1: After reset, `dma_req`, `head_upd`, `irq_rxt` and `irq_txdw` are 0, and `head_out` and `used_level` are 0.
- R2: The candidate count is `used_level`. For an aligned request (`wb_aligned`=1) the count is ANDed with the inverse of the mask LINE_BYTES/DESC_BYTES-1, which is 3 for the default sizes. For an unaligned request the count is left as it is.
- R3: If head plus the candidate count is at least `cfg_len`, the count becomes `cfg_len` minus head and a follow-up is marked. That follow-up runs by itself after completion, with the stored mask.
- R4: A computed count of zero issues no write.
- R5: `dma_addr` is `cfg_base` + head*DESC_BYTES and `dma_len` is count*DESC_BYTES.
- R6: `dma_req` rises `cfg_delay`+1 clock edges after the request is sampled and lasts one cycle. While `pause` is high the delay is frozen and no write is issued.
- R7: When `dma_done` arrives, head advances by the count and wraps to head+count-`cfg_len` when it reaches `cfg_len`. `head_upd` pulses, and `used_level` drops by the count.
- R8: A request that arrives while a write is in flight with a smaller mask (unaligned over aligned) is merged and issued after completion. Any other in-flight request is dropped.
- R9: The per-packet timer reloads from `tmr_pkt_load` on every `tmr_evt[0]`. It expires `tmr_pkt_load`+1 edges after the last event. The cause output pulses for one cycle on the edge after expiry, and the expiry forces an unaligned writeback.
- R10: The absolute timer loads from `tmr_abs_load` on `tmr_evt[1]` only when it is not already running, so a second event does not delay its expiry.
- R11: With `IS_TX`=0 an expiry drives `irq_rxt` and `irq_txdw` stays 0. With `IS_TX`=1 it drives `irq_txdw` and `irq_rxt` stays 0.
- R12: At most one write is outstanding: `dma_req` never pulses on two consecutive cycles, and no new write starts before `dma_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_len | input | RING_AW+1 | Ring length in descriptors |
| cfg_delay | input | DLY_W | Cycles between request and write issue |
| pause | input | 1 | Freezes the issue delay |
| used_push | input | 1 | One descriptor enters the used queue |
| wb_req | input | 1 | Writeback request |
| wb_aligned | input | 1 | Request asks for cache-line alignment |
| tmr_evt | input | 2 | Bit 0 packet-timer event, bit 1 absolute-timer event |
| tmr_pkt_load | input | TMR_W | Per-packet timer reload value |
| tmr_abs_load | input | TMR_W | Absolute timer load value |
| dma_req | output | 1 | One-cycle write request |
| dma_addr | output | ADDR_W | Write start address |
| dma_len | output | RING_AW+1+log2(DESC_BYTES) | Write length in bytes |
| dma_done | input | 1 | Write completion pulse |
| head_out | output | RING_AW | Published head index |
| head_upd | output | 1 | Head was updated this cycle |
| retire_cnt | output | RING_AW+1 | Entries retired by the last completion |
| used_level | output | RING_AW+1 | Entries waiting in the used queue |
| irq_rxt | output | 1 | Receive-timer cause pulse |
| irq_txdw | output | 1 | Descriptor-written cause pulse |

## Verification
The bench builds a 16-entry index space with 16-byte descriptors and 64-byte lines, which gives an alignment mask of 3. It uses a ring of 10 entries and an issue delay of 2. A ring length that is not a multiple of the line count lets clipping, wrapping to zero and aligned round-down to zero all occur within a few requests. A second instance with `IS_TX`=1 shares every input, so both interrupt-cause variants are checked against the same timer events. The two timer reload values are kept small, so that the restart and no-restart behaviours can be told apart by exact edge counts.

// File: rtl/desc_wb_engine.sv
module desc_wb_engine #(
  parameter int RING_AW    = 6,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  parameter int LINE_BYTES = 64,
  parameter int DLY_W      = 8,
  parameter int TMR_W      = 16,
  parameter bit IS_TX      = 1'b0,
  localparam int CNT_W     = RING_AW + 1,
  localparam int DSH       = $clog2(DESC_BYTES),
  localparam int LEN_W     = CNT_W + DSH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_len,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              pause,
  input  logic              used_push,
  input  logic              wb_req,
  input  logic              wb_aligned,
  input  logic [1:0]        tmr_evt,
  input  logic [TMR_W-1:0]  tmr_pkt_load,
  input  logic [TMR_W-1:0]  tmr_abs_load,
  output logic              dma_req,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  input  logic              dma_done,
  output logic [RING_AW-1:0] head_out,
  output logic              head_upd,
  output logic [CNT_W-1:0]  retire_cnt,
  output logic [CNT_W-1:0]  used_level,
  output logic              irq_rxt,
  output logic              irq_txdw
);
  localparam logic [CNT_W-1:0] ALIGN_MASK = CNT_W'(LINE_BYTES / DESC_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BUSY} st_t;
  st_t st;

  logic [CNT_W-1:0]   used_q, wb_out, mask_q;
  logic               more_q, rearm_q, irq_q;
  logic [DLY_W-1:0]   dly_q;
  logic [RING_AW-1:0] head_q;
  logic [1:0]         tmr_exp;

  // interrupt-delay timers: 0 restarts on every event, 1 runs to completion
  for (genvar gi = 0; gi < 2; gi++) begin : g_tmr
    logic [TMR_W-1:0] cnt;
    logic             run;
    wire [TMR_W-1:0]  load    = (gi == 0) ? tmr_pkt_load : tmr_abs_load;
    wire              restart = tmr_evt[gi] && ((gi == 0) || !run);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        run <= 1'b0;
      end else if (restart) begin
        cnt <= load;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) run <= 1'b0;
        else           cnt <= cnt - TMR_W'(1);
      end
    assign tmr_exp[gi] = run && (cnt == '0) && !restart;
  end

  wire force_wb = |tmr_exp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= force_wb;

  if (IS_TX) begin : g_tx
    assign irq_txdw = irq_q;
    assign irq_rxt  = 1'b0;
  end else begin : g_rx
    assign irq_rxt  = irq_q;
    assign irq_txdw = 1'b0;
  end

  // count computation
  wire              req_any   = wb_req | force_wb;
  wire [CNT_W-1:0]  req_mask  = force_wb ? '0 : (wb_aligned ? ALIGN_MASK : '0);
  wire              go        = rearm_q | req_any;
  wire              merge_now = req_any && (req_mask < mask_q);
  wire [CNT_W-1:0]  eff_mask  = rearm_q ? (merge_now ? req_mask : mask_q) : req_mask;
  wire [CNT_W-1:0]  head_ext  = CNT_W'(head_q);
  wire              clip      = ({1'b0, head_ext} + {1'b0, used_q}) >= {1'b0, cfg_len};
  wire [CNT_W-1:0]  cnt_calc  = clip ? (cfg_len - head_ext) : (used_q & ~eff_mask);
  wire [CNT_W-1:0]  head_sum  = head_ext + wb_out;
  wire [CNT_W-1:0]  head_wrap = (head_sum >= cfg_len) ? (head_sum - cfg_len) : head_sum;
  wire              retire    = (st == S_BUSY) && dma_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) used_q <= '0;
    else        used_q <= used_q + CNT_W'(used_push) - (retire ? wb_out : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      wb_out     <= '0;
      mask_q     <= '0;
      more_q     <= 1'b0;
      rearm_q    <= 1'b0;
      dly_q      <= '0;
      head_q     <= '0;
      dma_req    <= 1'b0;
      dma_addr   <= '0;
      dma_len    <= '0;
      head_upd   <= 1'b0;
      retire_cnt <= '0;
    end else begin
      dma_req  <= 1'b0;
      head_upd <= 1'b0;
      if (st != S_IDLE && merge_now) begin
        more_q <= 1'b1;
        mask_q <= req_mask;
      end
      case (st)
        S_IDLE: if (go) begin
          rearm_q <= 1'b0;
          mask_q  <= eff_mask;
          more_q  <= clip;
          if (cnt_calc != '0) begin
            wb_out <= cnt_calc;
            dly_q  <= cfg_delay;
            st     <= S_WAIT;
          end
        end
        S_WAIT: if (!pause) begin
          if (dly_q == '0) begin
            dma_req  <= 1'b1;
            dma_addr <= cfg_base + (ADDR_W'(head_q) << DSH);
            dma_len  <= LEN_W'(wb_out) << DSH;
            st       <= S_BUSY;
          end else begin
            dly_q <= dly_q - DLY_W'(1);
          end
        end
        S_BUSY: if (dma_done) begin
          head_q     <= RING_AW'(head_wrap);
          head_upd   <= 1'b1;
          retire_cnt <= wb_out;
          wb_out     <= '0;
          rearm_q    <= more_q | merge_now;
          more_q     <= 1'b0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end

  assign head_out   = head_q;
  assign used_level = used_q;

  p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && !dma_done) |=> !dma_req);
  p_len_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_len != '0));
  p_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && pause) |=> !dma_req);
  p_done_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> head_upd);
  p_head_rng_r7: assert property (@(posedge clk) disable iff (!rst_n)
    head_upd |-> (CNT_W'(head_q) < cfg_len));
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_wb |=> (irq_rxt | irq_txdw));
  p_irq_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rxt && irq_txdw));
endmodule

// File: tb/desc_wb_engine_bench.sv
module desc_wb_engine_bench;
  localparam int AW = 4;
  localparam int CW = AW + 1;
  localparam int LW = CW + 4;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int LEN = 10;
  // push count, aligned, first write count, follow-up write count
  localparam int VEC [0:5][0:3] = '{
    '{5, 1, 4, 0}, '{2, 1, 0, 0}, '{0, 0, 3, 0},
    '{6, 1, 3, 0}, '{6, 1, 8, 0}, '{4, 0, 2, 3}};

  logic clk = 0, rst_n = 0;
  logic pause = 0, used_push = 0, wb_req = 0, wb_aligned = 0, dma_done = 0;
  logic [1:0] tmr_evt = 0;
  logic dma_req, head_upd, irq_rxt, irq_txdw, t_req, t_upd, t_rxt, t_txdw;
  logic [31:0] dma_addr, t_addr;
  logic [LW-1:0] dma_len, t_len;
  logic [AW-1:0] head_out, t_head;
  logic [CW-1:0] retire_cnt, used_level, t_ret, t_used;
  int total = 0, bad = 0, n_dma = 0, resp = 0, mh = 0, mu = 0;
  logic [31:0] log_addr [0:63];
  int log_len [0:63];

  always #2 clk = ~clk;

  desc_wb_engine #(.RING_AW(AW), .DESC_BYTES(16), .LINE_BYTES(64), .IS_TX(1'b0)) u_desc_wb_engine (
    .clk, .rst_n, .cfg_base(BASE), .cfg_len(CW'(LEN)), .cfg_delay(8'd2), .pause, .used_push,
    .wb_req, .wb_aligned, .tmr_evt, .tmr_pkt_load(16'd6), .tmr_abs_load(16'd6),
    .dma_req, .dma_addr, .dma_len, .dma_done, .head_out, .head_upd, .retire_cnt,
    .used_level, .irq_rxt, .irq_txdw);

  desc_wb_engine #(.RING_AW(AW), .DESC_BYTES(16), .LINE_BYTES(64), .IS_TX(1'b1)) u_tx (
    .clk, .rst_n, .cfg_base(BASE), .cfg_len(CW'(LEN)), .cfg_delay(8'd2), .pause, .used_push,
    .wb_req, .wb_aligned, .tmr_evt, .tmr_pkt_load(16'd6), .tmr_abs_load(16'd6),
    .dma_req(t_req), .dma_addr(t_addr), .dma_len(t_len), .dma_done, .head_out(t_head),
    .head_upd(t_upd), .retire_cnt(t_ret), .used_level(t_used), .irq_rxt(t_rxt), .irq_txdw(t_txdw));

  always @(negedge clk) begin
    dma_done = 0;
    if (dma_req) begin
      if (n_dma < 64) begin
        log_addr[n_dma] = dma_addr;
        log_len[n_dma] = int'(dma_len);
      end
      n_dma++;
      resp = 6;
    end else if (resp != 0) begin
      resp--;
      if (resp == 0) dma_done = 1;
    end
  end

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic push(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) used_push = 1;
    end
    @(negedge clk) used_push = 0;
  endtask

  task automatic req(logic al);
    @(negedge clk) begin wb_req = 1; wb_aligned = al; end
    @(negedge clk) wb_req = 0;
  endtask

  task automatic pulse(int i);
    @(negedge clk) tmr_evt[i] = 1;
    @(negedge clk) tmr_evt[i] = 0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic chk_write(string r, int idx, int cnt, int h);
    chk({r, " addr"}, int'(log_addr[idx] - BASE), h * 16);
    chk({r, " len"}, log_len[idx], cnt * 16);
  endtask

  task automatic chk_state(string r, int h, int u);
    chk({r, " head"}, int'(head_out), h);
    chk({r, " used"}, int'(used_level), u);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0, n;
    repeat (3) @(negedge clk);
    chk("R1 dma_req", int'(dma_req), 0);
    chk("R1 head_upd", int'(head_upd), 0);
    chk("R1 irq", int'({irq_rxt, irq_txdw, t_rxt, t_txdw}), 0);
    chk_state("R1", 0, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R7 vector walk
    for (int v = 0; v < 6; v++) begin
      n0 = n_dma;
      push(VEC[v][0]);
      mu += VEC[v][0];
      req(VEC[v][1] != 0);
      settle();
      chk("R4 R3 write count", n_dma - n0, (VEC[v][2] != 0 ? 1 : 0) + (VEC[v][3] != 0 ? 1 : 0));
      if (VEC[v][2] != 0) begin
        chk_write("R2 R5", n0, VEC[v][2], mh);
        mh = (mh + VEC[v][2]) % LEN;
        mu -= VEC[v][2];
      end
      if (VEC[v][3] != 0) begin
        chk_write("R3 R5 follow-up", n0 + 1, VEC[v][3], mh);
        mh = (mh + VEC[v][3]) % LEN;
        mu -= VEC[v][3];
      end
      chk_state("R7", mh, mu);
    end
    chk("R7 retire_cnt", int'(retire_cnt), 3);

    // R6 delay, R8 dropped in-flight request: head 3 used 0
    n0 = n_dma;
    push(5);
    req(1'b0);
    n = 0;
    while (!dma_req && n < 50) begin @(negedge clk); n++; end
    chk("R6 issue delay", n, 3);
    push(3);
    req(1'b1);
    settle();
    chk("R8 drop count", n_dma - n0, 1);
    chk_write("R8 drop", n0, 5, 3);
    chk_state("R8 drop", 8, 3);

    // R3 flush with clip at ring end
    n0 = n_dma;
    req(1'b0);
    settle();
    chk("R3 flush count", n_dma - n0, 2);
    chk_write("R3 clip", n0, 2, 8);
    chk_write("R3 wrap", n0 + 1, 1, 0);
    chk_state("R3 R7 wrap", 1, 0);

    // R8 merge: aligned in flight, unaligned arrives
    n0 = n_dma;
    push(6);
    req(1'b1);
    req(1'b0);
    settle();
    chk("R8 merge count", n_dma - n0, 2);
    chk_write("R8 first", n0, 4, 1);
    chk_write("R8 merged", n0 + 1, 2, 5);
    chk_state("R8 merge", 7, 0);

    // R6 pause
    n0 = n_dma;
    push(2);
    pause = 1;
    req(1'b0);
    repeat (20) @(negedge clk);
    chk("R6 paused", n_dma - n0, 0);
    pause = 0;
    settle();
    chk("R6 released", n_dma - n0, 1);
    chk_write("R6", n0, 2, 7);
    chk_state("R6", 9, 0);

    // R9 packet timer restart + forced unaligned writeback, R11 variants
    n0 = n_dma;
    push(1);
    pulse(0);
    pulse(0);
    n = 0;
    while (!irq_rxt && n < 50) begin @(negedge clk); n++; end
    chk("R9 packet timer expiry", n, 7);
    chk("R11 tx variant cause", int'(t_txdw), 1);
    chk("R11 rx variant other cause", int'(irq_txdw), 0);
    chk("R11 tx variant other cause", int'(t_rxt), 0);
    @(negedge clk);
    chk("R9 single-cycle cause", int'(irq_rxt), 0);
    settle();
    chk("R9 forced count", n_dma - n0, 1);
    chk_write("R9 forced", n0, 1, 9);
    chk_state("R9", 0, 0);

    // R10 absolute timer not restarted
    pulse(1);
    pulse(1);
    n = 0;
    while (!irq_rxt && n < 50) begin @(negedge clk); n++; end
    chk("R10 absolute expiry", n, 5);
    settle();
    chk("R12 tx instance head agrees", int'(t_head), int'(head_out));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule